// File: doc/BRIEF.md
# Forty-Bit Signed Barrel Shifter

This block moves a 40-bit datapath value left or right by a signed amount in one pass. The operand is either a full 40-bit accumulator word or a 16-bit memory word widened to 40 bits. The amount comes from one of three places: a 6-bit immediate carried with the operation, a 5-bit count field held in a status register, or the low six bits of a 16-bit temporary register. A positive amount moves bits toward the MSB and a negative amount moves them toward the LSB. Bits vacated at the bottom always become zero. Bits vacated at the top become copies of the sign when the sign-extension mode input is high, and zeros when it is low.

The allowed range is lopsided. Left moves go up to 31 places. Right moves go up to 16 places, and any more negative amount is limited to 16. The result is captured in an output register, so it appears one clock after the operands. It then feeds the ALU or a store path. A two-state output stage (`OS_EMPTY`, `OS_FULL`) drives the valid flag. The stage goes from `OS_EMPTY` to `OS_FULL` when `in_valid` is high. It stays in `OS_FULL` while `in_valid` stays high. It returns from `OS_FULL` to `OS_EMPTY` when `in_valid` is low, and it stays in `OS_EMPTY` while `in_valid` is low. Reset forces `OS_EMPTY`.

Top module: `barrel_shift40`

## Requirements
- R1: While `rst_n` is low, and after it is released with no input presented, `out_valid` is 0 and `out_data` is 0.
- R2: A result presented with `in_valid` high appears on `out_data` with `out_valid` high exactly one clock later. A cycle with `in_valid` low gives `out_valid` low on the next clock and leaves `out_data` unchanged, whatever the other inputs do.
- R3: A positive count n (1..31) gives the operand shifted toward the MSB by n. The low n bits are zero and bits moved past bit 39 are lost.
- R4: A negative count -n (n = 1..16) gives the operand shifted toward the LSB by n. The top n bits copy operand bit 39 when `sxm`=1 and are zero when `sxm`=0. Bits moved below bit 0 are lost.
- R5: Any count more negative than -16 acts as -16. The effective count always lies in -16..+31.
- R6: `cnt_sel` picks the count: 0 selects `imm_cnt` (6-bit two's complement), 1 selects `stat_cnt` (5-bit two's complement, -16..+15), 2 selects `treg[5:0]` as 6-bit two's complement with `treg[15:6]` ignored, and 3 selects a count of zero (pass-through).
- R7: With `src_mem`=0 the operand is `acc_in`. With `src_mem`=1 the operand is `mem_in`, widened to 40 bits with copies of `mem_in[15]` when `sxm`=1 and with zeros when `sxm`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands present this cycle |
| src_mem | input | 1 | 1: use `mem_in`, 0: use `acc_in` |
| acc_in | input | 40 | Accumulator operand |
| mem_in | input | 16 | Memory operand |
| cnt_sel | input | 2 | Count source: 0 imm, 1 status, 2 temp reg, 3 zero |
| imm_cnt | input | 6 | Immediate signed count |
| stat_cnt | input | 5 | Status-register signed count |
| treg | input | 16 | Temporary register, low 6 bits used |
| sxm | input | 1 | Sign-extension mode |
| out_valid | output | 1 | Result valid |
| out_data | output | 40 | Shifted result |

## Verification
The bench applies the extreme counts: +31, -16, and an out-of-range -32 from both the immediate and the temporary register. A design without the clamp would shift right by up to 32 and clear far too much of the word. Negative operands are shifted right with the mode bit both set and clear. A design that ignores the mode bit, or that fills from the wrong end, gives the wrong upper bits. The bench also loads temporary-register values whose upper bits are set while their low six bits are positive, and 16-bit memory words with bit 15 set. These expose a design that reads too many count bits or widens the memory word the wrong way. It lowers `in_valid` while the other inputs change, to catch a register that captures data it should ignore.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
    typedef enum logic [1:0] {
        CNT_IMM  = 2'd0,
        CNT_STAT = 2'd1,
        CNT_TREG = 2'd2,
        CNT_ZERO = 2'd3
    } cnt_src_e;

    typedef enum logic {
        OS_EMPTY = 1'b0,
        OS_FULL  = 1'b1
    } out_state_e;
endpackage

// File: rtl/bsh_count_sel.sv
module bsh_count_sel
    import bsh_pkg::*;
#(
    parameter int IMMW = 6,
    parameter int STW  = 5,
    parameter int TW   = 16,
    parameter int TBITS = 6,
    parameter int LMAX = 31,
    parameter int RMAX = 16,
    parameter int CW   = 7
) (
    input  logic [1:0]      cnt_sel,
    input  logic [IMMW-1:0] imm_cnt,
    input  logic [STW-1:0]  stat_cnt,
    input  logic [TW-1:0]   treg,
    output logic [CW-1:0]   eff_cnt
);
    logic [CW-1:0] raw;
    int            raw_i;

    always_comb begin
        unique case (cnt_src_e'(cnt_sel))
            CNT_IMM:  raw = {{(CW-IMMW){imm_cnt[IMMW-1]}}, imm_cnt};
            CNT_STAT: raw = {{(CW-STW){stat_cnt[STW-1]}}, stat_cnt};
            CNT_TREG: raw = {{(CW-TBITS){treg[TBITS-1]}}, treg[TBITS-1:0]};
            CNT_ZERO: raw = '0;
            default:  raw = '0;
        endcase
    end

    always_comb begin
        raw_i = int'($signed(raw));
        if (raw_i < -RMAX)
            eff_cnt = CW'(-RMAX);
        else if (raw_i > LMAX)
            eff_cnt = CW'(LMAX);
        else
            eff_cnt = raw;
    end
endmodule

// File: rtl/bsh_operand_ext.sv
module bsh_operand_ext #(
    parameter int DW = 40,
    parameter int MW = 16
) (
    input  logic          src_mem,
    input  logic          sxm,
    input  logic [DW-1:0] acc_in,
    input  logic [MW-1:0] mem_in,
    output logic [DW-1:0] opd
);
    logic fill;

    always_comb begin
        fill = sxm & mem_in[MW-1];
        if (src_mem)
            opd = {{(DW-MW){fill}}, mem_in};
        else
            opd = acc_in;
    end
endmodule

// File: rtl/bsh_shift_core.sv
module bsh_shift_core #(
    parameter int DW = 40,
    parameter int CW = 7
) (
    input  logic [DW-1:0] opd,
    input  logic [CW-1:0] cnt,
    input  logic          sxm,
    output logic [DW-1:0] res
);
    logic            fill;
    logic [CW-1:0]   mag;
    logic [2*DW-1:0] wide;

    always_comb begin
        fill = sxm & opd[DW-1];
        wide = '0;
        if (cnt[CW-1]) begin
            mag  = CW'(0) - cnt;
            wide = {{DW{fill}}, opd} >> mag;
            res  = wide[DW-1:0];
        end else begin
            mag  = cnt;
            res  = opd << mag;
        end
    end
endmodule

// File: rtl/barrel_shift40.sv
module barrel_shift40
    import bsh_pkg::*;
#(
    parameter int DW    = 40,
    parameter int MW    = 16,
    parameter int IMMW  = 6,
    parameter int STW   = 5,
    parameter int TW    = 16,
    parameter int TBITS = 6,
    parameter int LMAX  = 31,
    parameter int RMAX  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            src_mem,
    input  logic [DW-1:0]   acc_in,
    input  logic [MW-1:0]   mem_in,
    input  logic [1:0]      cnt_sel,
    input  logic [IMMW-1:0] imm_cnt,
    input  logic [STW-1:0]  stat_cnt,
    input  logic [TW-1:0]   treg,
    input  logic            sxm,
    output logic            out_valid,
    output logic [DW-1:0]   out_data
);
    localparam int CW = $clog2(LMAX + 1) + 2;

    logic [CW-1:0] eff_cnt;
    logic [DW-1:0] ext_opd;
    logic [DW-1:0] shifted;

    out_state_e state_q, state_d;
    logic [DW-1:0] data_q;

    bsh_count_sel #(
        .IMMW(IMMW), .STW(STW), .TW(TW), .TBITS(TBITS),
        .LMAX(LMAX), .RMAX(RMAX), .CW(CW)
    ) u_cnt (
        .cnt_sel (cnt_sel),
        .imm_cnt (imm_cnt),
        .stat_cnt(stat_cnt),
        .treg    (treg),
        .eff_cnt (eff_cnt)
    );

    bsh_operand_ext #(.DW(DW), .MW(MW)) u_ext (
        .src_mem(src_mem),
        .sxm    (sxm),
        .acc_in (acc_in),
        .mem_in (mem_in),
        .opd    (ext_opd)
    );

    bsh_shift_core #(.DW(DW), .CW(CW)) u_core (
        .opd(ext_opd),
        .cnt(eff_cnt),
        .sxm(sxm),
        .res(shifted)
    );

    always_comb begin
        unique case (state_q)
            OS_EMPTY: state_d = in_valid ? OS_FULL : OS_EMPTY;
            OS_FULL:  state_d = in_valid ? OS_FULL : OS_EMPTY;
            default:  state_d = OS_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OS_EMPTY;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (in_valid)
                data_q <= shifted;
        end
    end

    always_comb begin
        out_valid = (state_q == OS_FULL);
        out_data  = data_q;
    end
endmodule

// File: rtl/bsh_checker.sv
module bsh_checker #(
    parameter int DW   = 40,
    parameter int CW   = 7,
    parameter int LMAX = 31,
    parameter int RMAX = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          sxm,
    input logic [CW-1:0] eff_cnt,
    input logic [DW-1:0] ext_opd,
    input logic          out_valid,
    input logic [DW-1:0] out_data
);
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_drop_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data)));

    p_low_zero_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !eff_cnt[CW-1] && (eff_cnt != '0)) |=> (out_data[0] == 1'b0));

    p_sign_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && eff_cnt[CW-1] && sxm) |=> (out_data[DW-1] == $past(ext_opd[DW-1])));

    p_zero_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && eff_cnt[CW-1] && !sxm) |=> (out_data[DW-1] == 1'b0));

    p_count_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (int'($signed(eff_cnt)) >= -RMAX && int'($signed(eff_cnt)) <= LMAX));
endmodule

bind barrel_shift40 bsh_checker #(
    .DW(DW), .CW(CW), .LMAX(LMAX), .RMAX(RMAX)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .sxm      (sxm),
    .eff_cnt  (eff_cnt),
    .ext_opd  (ext_opd),
    .out_valid(out_valid),
    .out_data (out_data)
);

// File: tb/sim_barrel_shift40.sv
module sim_barrel_shift40;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        src_mem = 1'b0;
    logic [39:0] acc_in = '0;
    logic [15:0] mem_in = '0;
    logic [1:0]  cnt_sel = '0;
    logic [5:0]  imm_cnt = '0;
    logic [4:0]  stat_cnt = '0;
    logic [15:0] treg = '0;
    logic        sxm = 1'b0;
    logic        out_valid;
    logic [39:0] out_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    barrel_shift40 u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_mem(src_mem),
        .acc_in(acc_in), .mem_in(mem_in), .cnt_sel(cnt_sel), .imm_cnt(imm_cnt),
        .stat_cnt(stat_cnt), .treg(treg), .sxm(sxm),
        .out_valid(out_valid), .out_data(out_data)
    );

    typedef struct packed {
        logic        src;
        logic        sx;
        logic [1:0]  sel;
        logic [5:0]  imm;
        logic [4:0]  st;
        logic [15:0] tr;
        logic [15:0] mem;
        logic [39:0] acc;
        logic [39:0] exp;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,2'd0,6'd31,5'd0,16'h0000,16'h0000,40'h00_0000_0001,40'h00_8000_0000}, // R3 max left
        '{1'b0,1'b0,2'd0,6'd8, 5'd0,16'h0000,16'h0000,40'h80_0000_00FF,40'h00_0000_FF00}, // R3 top bits lost
        '{1'b0,1'b1,2'd0,6'h30,5'd0,16'h0000,16'h0000,40'h80_0000_0000,40'hFF_FF80_0000}, // R4 sign fill -16
        '{1'b0,1'b0,2'd0,6'h30,5'd0,16'h0000,16'h0000,40'h80_0000_0000,40'h00_0080_0000}, // R4 zero fill -16
        '{1'b0,1'b0,2'd1,6'd5, 5'h10,16'h0003,16'h0000,40'h00_0001_0000,40'h00_0000_0001}, // R6 status -16
        '{1'b0,1'b0,2'd1,6'd0, 5'd15,16'h0000,16'h0000,40'h00_0000_0001,40'h00_0000_8000}, // R6 status +15
        '{1'b0,1'b0,2'd2,6'd9, 5'd0,16'hFFC3,16'h0000,40'h00_0000_0001,40'h00_0000_0008}, // R6 treg upper ignored
        '{1'b0,1'b1,2'd2,6'd0, 5'd0,16'h003F,16'h0000,40'h80_0000_0002,40'hC0_0000_0001}, // R6 treg -1
        '{1'b0,1'b0,2'd2,6'd0, 5'd0,16'h0020,16'h0000,40'hFF_FFFF_0000,40'h00_00FF_FFFF}, // R5 treg -32 clamp
        '{1'b0,1'b1,2'd0,6'h20,5'd0,16'h0000,16'h0000,40'h80_0000_0000,40'hFF_FF80_0000}, // R5 imm -32 clamp
        '{1'b1,1'b1,2'd3,6'd7, 5'd3,16'h0005,16'h8001,40'h12_3456_789A,40'hFF_FFFF_8001}, // R7 mem sign ext
        '{1'b1,1'b0,2'd3,6'd7, 5'd3,16'h0005,16'h8001,40'h12_3456_789A,40'h00_0000_8001}, // R7 mem zero ext
        '{1'b1,1'b1,2'd0,6'd4, 5'd0,16'h0000,16'h8000,40'h00_0000_0000,40'hFF_FFF8_0000}, // R7 mem then left
        '{1'b0,1'b1,2'd3,6'd9, 5'd9,16'h0009,16'hFFFF,40'h12_3456_789A,40'h12_3456_789A}, // R6 zero count
        '{1'b0,1'b1,2'd0,6'h3F,5'd0,16'h0000,16'h0000,40'h00_0000_0001,40'h00_0000_0000}  // R4 bit lost low
    };

    task automatic check(input string tag, input logic [39:0] got, input logic [39:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        src_mem = v.src; sxm = v.sx; cnt_sel = v.sel; imm_cnt = v.imm;
        stat_cnt = v.st; treg = v.tr; mem_in = v.mem; acc_in = v.acc;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {39'd0, out_valid}, 40'd0);
        check("R1 data in reset", out_data, 40'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after release", {39'd0, out_valid}, 40'd0);
        check("R1 data after release", out_data, 40'd0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            in_valid = 1'b1;
            @(negedge clk);
            check($sformatf("R2 valid vec %0d", i), {39'd0, out_valid}, 40'd1);
            check($sformatf("R3/R4/R5/R6/R7 vec %0d", i), out_data, VEC[i].exp);
        end

        // R2: inputs change with in_valid low, output holds
        in_valid = 1'b0;
        acc_in = 40'hAA_AAAA_AAAA; cnt_sel = 2'd3;
        @(negedge clk);
        check("R2 valid drops", {39'd0, out_valid}, 40'd0);
        check("R2 data held", out_data, VEC[NV-1].exp);
        acc_in = 40'h55_5555_5555; imm_cnt = 6'd1; cnt_sel = 2'd0;
        @(negedge clk);
        check("R2 data still held", out_data, VEC[NV-1].exp);

        // R3 single-bit left by 1 then R4 right by 1 zero fill
        apply('{1'b0,1'b0,2'd0,6'd1,5'd0,16'h0,16'h0,40'hC0_0000_0001,40'h0});
        in_valid = 1'b1;
        @(negedge clk);
        check("R3 left by one", out_data, 40'h80_0000_0002);
        imm_cnt = 6'h3F;
        @(negedge clk);
        check("R4 right by one zero fill", out_data, 40'h60_0000_0000);
        sxm = 1'b1;
        @(negedge clk);
        check("R4 right by one sign fill", out_data, 40'hE0_0000_0000);

        // R1: reset clears a full stage
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 valid cleared", {39'd0, out_valid}, 40'd0);
        check("R1 data cleared", out_data, 40'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule